// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence for a four-beat burst into a synchronous burst memory. The controller presents an address and pulls either of two active-low strobes. One strobe serves the processor side and the other serves the cache-controller side. The block captures the address on that clock edge.

On every later edge where the active-low advance input is low, a two-bit beat counter steps. The low two address bits then follow one of two orderings. In linear order they are the start value plus the beat count, modulo 4. In interleaved order they are the start value XOR the beat count. The upper address bits keep the loaded value for the whole burst.

A new address can be strobed on every cycle, so the block also serves plain single-beat access. The order select is a level input, and 1 means interleaved. A board-level pull-up on that input gives interleaved order when it is left floating.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, `addr_out` is all zeros.
- R2: A clock edge where `strobe_cpu_n` or `strobe_ctl_n` is low captures `addr_in`, and `addr_out` equals that value in the following cycle.
- R3: With `order_sel` = 0, the low two bits of `addr_out` are (start + beats) mod 4, where beats is the number of advancing edges since the load (start 01 gives 01, 10, 11, 00).
- R4: With `order_sel` = 1, the low two bits of `addr_out` are start XOR beats (start 01 gives 01, 00, 11, 10; start 11 gives 11, 10, 01, 00).
- R5: The beat count steps only on edges where `adv_n` is low and no strobe is low; otherwise `addr_out` holds.
- R6: Bits above bit 1 of `addr_out` stay at the loaded value until the next strobe.
- R7: When a strobe and `adv_n` are low on the same edge, the load wins and the beat count restarts at zero.
- R8: On the fourth advancing edge after a load, the low bits wrap back to the start value.
- R9: Strobes on consecutive edges load a new address each cycle, and no burst step comes in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | Start address of a burst |
| strobe_cpu_n | input | 1 | Processor-side load strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_out | output | ADDR_W | Current burst address |

## Verification
All state changes happen on the rising edge, and `addr_out` is combinational from that state. A load or an advance sampled on one edge therefore shows up in the cycle that follows. A change of `order_sel` shows up in the same cycle. The bench drives inputs on the falling edge. It updates its own model of the start address and beat count right after each rising edge, then compares `addr_out` two time units later. That leaves exactly one register between each stimulus and its check. Directed bursts cover all four start values in both orders through the wrap, and seeded random traffic follows.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_hi;
  logic [1:0]      base_lo;
  logic [1:0]      beat;
  logic            load;

  assign load = !strobe_cpu_n || !strobe_ctl_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi <= '0;
      base_lo <= '0;
      beat    <= '0;
    end else if (load) begin
      base_hi <= addr_in[ADDR_W-1:2];
      base_lo <= addr_in[1:0];
      beat    <= '0;
    end else if (!adv_n) begin
      beat <= beat + 2'd1;
    end
  end

  assign addr_out = {base_hi, order_sel ? (base_lo ^ beat) : (base_lo + beat)};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_out
);
  logic ld;
  assign ld = !strobe_cpu_n || !strobe_ctl_n;

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> addr_out == $past(addr_in)); // R2

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv_n && !order_sel) |=>
      (order_sel || addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && adv_n) |=> ($stable(addr_out) || order_sel != $past(order_sel))); // R5

  AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(addr_out[ADDR_W-1:2])); // R6
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] addr_in = '0;
  logic          strobe_cpu_n = 1, strobe_ctl_n = 1, adv_n = 1, order_sel = 1;
  logic [AW-1:0] addr_out;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;

  burst_addr_seq #(.ADDR_W(AW)) dut (.*);

  always #5 clk = ~clk;

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] n, logic m);
    return {b[AW-1:2], m ? (b[1:0] ^ n) : 2'(b[1:0] + n)};
  endfunction

  task automatic check(string req);
    logic [AW-1:0] e = exp_addr(m_base, m_beat, order_sel);
    n_chk++;
    if (addr_out !== e) begin
      n_fail++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, e);
    end
  endtask

  task automatic cyc(logic [AW-1:0] a, logic sc, logic sk, logic av, logic md, string req);
    @(negedge clk);
    addr_in = a; strobe_cpu_n = sc; strobe_ctl_n = sk; adv_n = av; order_sel = md;
    @(posedge clk);
    if (!sc || !sk) begin m_base = a; m_beat = '0; end
    else if (!av) m_beat = m_beat + 2'd1;
    #2 check(req);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2 check("R1");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2 check("R1");

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a = {16'(16'h1A5 + s * 16'h111), 2'(s)};
        cyc(a, 0, 1, 1, m[0], "R2");
        for (int k = 0; k < 3; k++) cyc('0, 1, 1, 0, m[0], m ? "R4" : "R3");
        cyc('0, 1, 1, 1, m[0], "R5");
        cyc('0, 1, 1, 0, m[0], "R8");
        cyc('0, 1, 1, 0, m[0], "R6");
      end

    cyc(18'h2ABCD, 1, 0, 1, 0, "R2");
    cyc('0, 1, 1, 0, 0, "R3");
    cyc(18'h13572, 0, 1, 0, 0, "R7");
    cyc(18'h0F0F3, 1, 0, 0, 1, "R7");
    for (int k = 0; k < 6; k++) cyc(18'(k * 18'h1357), k[0], !k[0], 0, k[1], "R9");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r = 4'($urandom);
      cyc(18'($urandom), r[0] | r[1], r[0] | !r[1] | r[2], r[3] & r[2], $urandom_range(0, 7) != 0 ? order_sel : !order_sel, "R6");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule